// File: doc/BRIEF.md
# CAN Receive Mailbox Matching Engine

This block decides where a freshly received CAN frame goes. It holds an array of receive mailboxes. Each mailbox has a programmed identifier, a 4-bit status code and an acceptance mask. When a frame identifier is presented, the engine walks the mailboxes one per clock cycle, lowest index first. It picks the first matching mailbox that is free to receive. If every matching mailbox is already occupied, it picks the last one that matched and marks it as overrun.

Masks come from one of two sources, chosen by a mode input. In per-mailbox mode, every mailbox uses a private mask. In shared mode, one general mask covers most mailboxes, and two dedicated masks cover two fixed mailboxes (index 14 and index 15 by default). Mask writes take effect only while the freeze input is high.

A mailbox can be deactivated by a strobe at any time, including during a scan. If the strobe hits the mailbox that is currently the provisional winner, that candidate is dropped and the scan carries on. Programming several mailboxes with the same identifier turns them into a small receive queue that fills in index order.

Top module: `rxm_match_engine`

## Requirements
- R1: In ascending index order, the first matching mailbox whose code is EMPTY (4'b0100) receives the frame. The result kind is store (2'b01), the result index is that mailbox, and its code becomes FULL (4'b0010), which is also reported on res_code_o.
- R2: A matching mailbox whose code is FULL or OVERRUN is passed over. A later matching EMPTY mailbox still wins, however many occupied mailboxes matched before it.
- R3: When one or more mailboxes match but none is EMPTY, the highest-indexed matching mailbox is overwritten. The result kind is overrun (2'b10), and the code becomes and is reported as OVERRUN (4'b0110).
- R4: When no mailbox matches, the result kind is none (2'b00), and the result index and code are 0. A mailbox with code 4'b0000 (inactive) never matches.
- R5: For each identifier bit, a mask bit of 1 requires equality and a mask bit of 0 makes the bit don't-care.
- R6: With indiv_mask_mode_i high, each mailbox is compared through its own mask. These masks are written with msk_wr_shared_i low and msk_wr_idx_i set to the mailbox index.
- R7: With indiv_mask_mode_i low, mailbox 14 uses dedicated mask A, mailbox 15 uses dedicated mask B, and every other mailbox uses the general mask. These masks are written with msk_wr_shared_i high, and msk_wr_idx_i selects 0 for general, 1 for A and 2 for B. The per-mailbox masks are then ignored.
- R8: A mask write with freeze_i low has no effect.
- R9: If inact_en_i names the provisional winner during a scan, the winner is discarded and the scan continues from the next mailbox. The inactivated mailbox takes code 4'b0000 and no longer matches.
- R10: Mailboxes sharing one identifier take successive frames with that identifier in index order. Once all are full, the last one is overrun.
- R11: A frame accepted at a clock edge while busy_o is low produces a one-cycle done_o pulse after edge NUM_MB following that edge. busy_o is high in between, and frm_valid_i is ignored while busy_o is high.
- R12: After reset, every mailbox code is inactive, busy_o and done_o are low, and the result kind is none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| freeze_i | input | 1 | Enables mask writes when high |
| indiv_mask_mode_i | input | 1 | 1 selects per-mailbox masks, 0 selects the shared scheme |
| mb_wr_en_i | input | 1 | Writes identifier and code of one mailbox |
| mb_wr_idx_i | input | IW | Mailbox index for the write |
| mb_wr_id_i | input | ID_W | Identifier to program |
| mb_wr_code_i | input | 4 | Status code to program |
| msk_wr_en_i | input | 1 | Mask write strobe |
| msk_wr_shared_i | input | 1 | 1 writes a shared mask, 0 writes a per-mailbox mask |
| msk_wr_idx_i | input | IW | Mailbox index, or shared mask select |
| msk_wr_val_i | input | ID_W | Mask value |
| frm_valid_i | input | 1 | Presents a received frame identifier |
| frm_id_i | input | ID_W | Received identifier |
| inact_en_i | input | 1 | Deactivates one mailbox |
| inact_idx_i | input | IW | Mailbox to deactivate |
| busy_o | output | 1 | Scan in progress |
| done_o | output | 1 | One-cycle result pulse |
| res_kind_o | output | 2 | 00 none, 01 store, 10 overrun |
| res_idx_o | output | IW | Selected mailbox |
| res_code_o | output | 4 | Code written to the selected mailbox |

## Verification
The result arrives after edge NUM_MB following the accepting edge. The bench drives frm_valid_i at a falling edge, then counts falling edges until done_o and requires that count to be NUM_MB+1. It reads the result at that same falling edge. Inactivation strobes are placed by falling-edge count: a strobe driven at count k is sampled by the edge that compares mailbox k-1, so it lands after a chosen winner has been compared and before a later candidate. To check that a frame offered mid-scan is ignored, the bench watches done_o for twenty idle cycles and then queries the mailbox state with a fresh frame.

// File: rtl/rxm_pkg.sv
package rxm_pkg;
  localparam int CODE_W = 4;
  localparam logic [CODE_W-1:0] CODE_INACTIVE = 4'b0000;
  localparam logic [CODE_W-1:0] CODE_EMPTY    = 4'b0100;
  localparam logic [CODE_W-1:0] CODE_FULL     = 4'b0010;
  localparam logic [CODE_W-1:0] CODE_OVERRUN  = 4'b0110;

  typedef enum logic [1:0] {
    RES_NONE  = 2'b00,
    RES_STORE = 2'b01,
    RES_OVR   = 2'b10
  } res_kind_e;
endpackage

// File: rtl/rxm_mask_bank.sv
module rxm_mask_bank #(
  parameter int NUM_MB = 16,
  parameter int ID_W   = 29,
  parameter int DED_A  = 14,
  parameter int DED_B  = 15,
  localparam int IW    = $clog2(NUM_MB)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            freeze_i,
  input  logic            wr_en_i,
  input  logic            wr_shared_i,
  input  logic [IW-1:0]   wr_idx_i,
  input  logic [ID_W-1:0] wr_val_i,
  input  logic            indiv_mode_i,
  input  logic [IW-1:0]   rd_idx_i,
  output logic [ID_W-1:0] mask_o
);
  localparam logic [IW-1:0] SEL_GEN = IW'(0);
  localparam logic [IW-1:0] SEL_A   = IW'(1);
  localparam logic [IW-1:0] SEL_B   = IW'(2);
  localparam logic [IW-1:0] IDX_A   = IW'(DED_A);
  localparam logic [IW-1:0] IDX_B   = IW'(DED_B);

  logic            wr_ok;
  logic [ID_W-1:0] indiv_q [NUM_MB];
  logic [ID_W-1:0] gen_q, ded_a_q, ded_b_q;

  assign wr_ok = wr_en_i && freeze_i;

  // per-mailbox masks: plain RAM, no reset
  always_ff @(posedge clk) begin
    if (wr_ok && !wr_shared_i) begin
      indiv_q[wr_idx_i] <= wr_val_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gen_q   <= '1;
      ded_a_q <= '1;
      ded_b_q <= '1;
    end else if (wr_ok && wr_shared_i) begin
      if (wr_idx_i == SEL_GEN) gen_q   <= wr_val_i;
      if (wr_idx_i == SEL_A)   ded_a_q <= wr_val_i;
      if (wr_idx_i == SEL_B)   ded_b_q <= wr_val_i;
    end
  end

  always_comb begin
    if (indiv_mode_i)            mask_o = indiv_q[rd_idx_i];
    else if (rd_idx_i == IDX_A)  mask_o = ded_a_q;
    else if (rd_idx_i == IDX_B)  mask_o = ded_b_q;
    else                         mask_o = gen_q;
  end
endmodule

// File: rtl/rxm_mb_table.sv
module rxm_mb_table
  import rxm_pkg::*;
#(
  parameter int NUM_MB = 16,
  parameter int ID_W   = 29,
  localparam int IW    = $clog2(NUM_MB)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we_i,
  input  logic [IW-1:0]     cfg_idx_i,
  input  logic [ID_W-1:0]   cfg_id_i,
  input  logic [CODE_W-1:0] cfg_code_i,
  input  logic              upd_en_i,
  input  logic [IW-1:0]     upd_idx_i,
  input  logic [CODE_W-1:0] upd_code_i,
  input  logic              inact_en_i,
  input  logic [IW-1:0]     inact_idx_i,
  input  logic [IW-1:0]     rd_idx_i,
  output logic [ID_W-1:0]   rd_id_o,
  output logic [CODE_W-1:0] rd_code_o
);
  logic [ID_W-1:0]   id_q   [NUM_MB];
  logic [CODE_W-1:0] code_q [NUM_MB];

  always_ff @(posedge clk) begin
    if (cfg_we_i) id_q[cfg_idx_i] <= cfg_id_i;
  end

  // later assignments win: inactivation has the last word
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_MB; i++) code_q[i] <= CODE_INACTIVE;
    end else begin
      if (cfg_we_i)   code_q[cfg_idx_i]   <= cfg_code_i;
      if (upd_en_i)   code_q[upd_idx_i]   <= upd_code_i;
      if (inact_en_i) code_q[inact_idx_i] <= CODE_INACTIVE;
    end
  end

  assign rd_id_o   = id_q[rd_idx_i];
  assign rd_code_o = code_q[rd_idx_i];
endmodule

// File: rtl/rxm_id_compare.sv
module rxm_id_compare
  import rxm_pkg::*;
#(
  parameter int ID_W = 29
) (
  input  logic [ID_W-1:0]   frm_id_i,
  input  logic [ID_W-1:0]   mb_id_i,
  input  logic [ID_W-1:0]   mask_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              blocked_i,
  output logic              hit_o,
  output logic              free_o
);
  logic [ID_W-1:0] diff;

  assign diff   = (frm_id_i ^ mb_id_i) & mask_i;
  assign hit_o  = (diff == '0) && (code_i != CODE_INACTIVE) && !blocked_i;
  assign free_o = (code_i == CODE_EMPTY);
endmodule

// File: rtl/rxm_scan_ctrl.sv
module rxm_scan_ctrl
  import rxm_pkg::*;
#(
  parameter int NUM_MB = 16,
  parameter int ID_W   = 29,
  localparam int IW    = $clog2(NUM_MB)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frm_valid_i,
  input  logic [ID_W-1:0]   frm_id_i,
  input  logic              inact_en_i,
  input  logic [IW-1:0]     inact_idx_i,
  input  logic              hit_i,
  input  logic              free_i,
  output logic [ID_W-1:0]   scan_id_o,
  output logic [IW-1:0]     ptr_o,
  output logic              busy_o,
  output logic              upd_en_o,
  output logic [IW-1:0]     upd_idx_o,
  output logic [CODE_W-1:0] upd_code_o,
  output logic              done_o,
  output logic [1:0]        kind_o,
  output logic [IW-1:0]     idx_o,
  output logic [CODE_W-1:0] code_o
);
  localparam logic [IW-1:0] LAST = IW'(NUM_MB - 1);

  logic              busy_q, have_free_q, have_match_q;
  logic [IW-1:0]     ptr_q, win_q;
  logic [ID_W-1:0]   id_q;
  logic              hit_win, f_n, m_n, last;
  logic [IW-1:0]     w_n;
  res_kind_e         fin_kind;
  logic [CODE_W-1:0] fin_code;

  always_comb begin
    hit_win = inact_en_i && have_match_q && (inact_idx_i == win_q);
    f_n = have_free_q  && !hit_win;
    m_n = have_match_q && !hit_win;
    w_n = win_q;
    if (!f_n && hit_i) begin
      w_n = ptr_q;
      m_n = 1'b1;
      f_n = free_i;
    end
    last = busy_q && (ptr_q == LAST);
    if (f_n)      begin fin_kind = RES_STORE; fin_code = CODE_FULL;     end
    else if (m_n) begin fin_kind = RES_OVR;   fin_code = CODE_OVERRUN;  end
    else          begin fin_kind = RES_NONE;  fin_code = CODE_INACTIVE; end
  end

  assign upd_en_o   = last && m_n;
  assign upd_idx_o  = w_n;
  assign upd_code_o = fin_code;
  assign scan_id_o  = id_q;
  assign ptr_o      = ptr_q;
  assign busy_o     = busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q       <= 1'b0;
      have_free_q  <= 1'b0;
      have_match_q <= 1'b0;
      ptr_q        <= '0;
      win_q        <= '0;
      id_q         <= '0;
      done_o       <= 1'b0;
      kind_o       <= RES_NONE;
      idx_o        <= '0;
      code_o       <= CODE_INACTIVE;
    end else begin
      done_o <= 1'b0;
      if (!busy_q) begin
        if (frm_valid_i) begin
          busy_q       <= 1'b1;
          ptr_q        <= '0;
          id_q         <= frm_id_i;
          have_free_q  <= 1'b0;
          have_match_q <= 1'b0;
          win_q        <= '0;
        end
      end else begin
        have_free_q  <= f_n;
        have_match_q <= m_n;
        win_q        <= w_n;
        ptr_q        <= ptr_q + 1'b1;
        if (last) begin
          busy_q <= 1'b0;
          done_o <= 1'b1;
          kind_o <= fin_kind;
          idx_o  <= m_n ? w_n : '0;
          code_o <= fin_code;
        end
      end
    end
  end
endmodule

// File: rtl/rxm_match_engine.sv
module rxm_match_engine
  import rxm_pkg::*;
#(
  parameter int NUM_MB = 16,
  parameter int ID_W   = 29,
  parameter int DED_A  = 14,
  parameter int DED_B  = 15,
  localparam int IW    = $clog2(NUM_MB)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              freeze_i,
  input  logic              indiv_mask_mode_i,
  input  logic              mb_wr_en_i,
  input  logic [IW-1:0]     mb_wr_idx_i,
  input  logic [ID_W-1:0]   mb_wr_id_i,
  input  logic [CODE_W-1:0] mb_wr_code_i,
  input  logic              msk_wr_en_i,
  input  logic              msk_wr_shared_i,
  input  logic [IW-1:0]     msk_wr_idx_i,
  input  logic [ID_W-1:0]   msk_wr_val_i,
  input  logic              frm_valid_i,
  input  logic [ID_W-1:0]   frm_id_i,
  input  logic              inact_en_i,
  input  logic [IW-1:0]     inact_idx_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [1:0]        res_kind_o,
  output logic [IW-1:0]     res_idx_o,
  output logic [CODE_W-1:0] res_code_o
);
  logic [IW-1:0]     ptr;
  logic [ID_W-1:0]   scan_id, mb_id, mb_mask;
  logic [CODE_W-1:0] mb_code, upd_code;
  logic              hit, free, blocked, upd_en;
  logic [IW-1:0]     upd_idx;

  assign blocked = inact_en_i && (inact_idx_i == ptr);

  rxm_mask_bank #(.NUM_MB(NUM_MB), .ID_W(ID_W), .DED_A(DED_A), .DED_B(DED_B)) u_masks (
    .clk(clk), .rst(rst), .freeze_i(freeze_i),
    .wr_en_i(msk_wr_en_i), .wr_shared_i(msk_wr_shared_i),
    .wr_idx_i(msk_wr_idx_i), .wr_val_i(msk_wr_val_i),
    .indiv_mode_i(indiv_mask_mode_i), .rd_idx_i(ptr), .mask_o(mb_mask)
  );

  rxm_mb_table #(.NUM_MB(NUM_MB), .ID_W(ID_W)) u_tbl (
    .clk(clk), .rst(rst),
    .cfg_we_i(mb_wr_en_i), .cfg_idx_i(mb_wr_idx_i),
    .cfg_id_i(mb_wr_id_i), .cfg_code_i(mb_wr_code_i),
    .upd_en_i(upd_en), .upd_idx_i(upd_idx), .upd_code_i(upd_code),
    .inact_en_i(inact_en_i), .inact_idx_i(inact_idx_i),
    .rd_idx_i(ptr), .rd_id_o(mb_id), .rd_code_o(mb_code)
  );

  rxm_id_compare #(.ID_W(ID_W)) u_cmp (
    .frm_id_i(scan_id), .mb_id_i(mb_id), .mask_i(mb_mask),
    .code_i(mb_code), .blocked_i(blocked), .hit_o(hit), .free_o(free)
  );

  rxm_scan_ctrl #(.NUM_MB(NUM_MB), .ID_W(ID_W)) u_ctrl (
    .clk(clk), .rst(rst),
    .frm_valid_i(frm_valid_i), .frm_id_i(frm_id_i),
    .inact_en_i(inact_en_i), .inact_idx_i(inact_idx_i),
    .hit_i(hit), .free_i(free),
    .scan_id_o(scan_id), .ptr_o(ptr), .busy_o(busy_o),
    .upd_en_o(upd_en), .upd_idx_o(upd_idx), .upd_code_o(upd_code),
    .done_o(done_o), .kind_o(res_kind_o), .idx_o(res_idx_o), .code_o(res_code_o)
  );
endmodule

// File: rtl/rxm_match_checker.sv
module rxm_match_checker #(
  parameter int IW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          frm_valid_i,
  input logic          busy_o,
  input logic          done_o,
  input logic [1:0]    res_kind_o,
  input logic [IW-1:0] res_idx_o,
  input logic [3:0]    res_code_o
);
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  a_r11_done_ends_busy: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o);

  a_r11_accept: assert property (@(posedge clk) disable iff (rst)
    (frm_valid_i && !busy_o) |=> busy_o);

  a_r11_idle_no_done: assert property (@(posedge clk) disable iff (rst)
    !busy_o |=> !done_o);

  a_r1_store_code: assert property (@(posedge clk) disable iff (rst)
    (done_o && res_kind_o == 2'b01) |-> res_code_o == 4'b0010);

  a_r3_overrun_code: assert property (@(posedge clk) disable iff (rst)
    (done_o && res_kind_o == 2'b10) |-> res_code_o == 4'b0110);

  a_r4_none_zero: assert property (@(posedge clk) disable iff (rst)
    (done_o && res_kind_o == 2'b00) |-> (res_idx_o == '0 && res_code_o == 4'b0000));

  a_r4_kind_legal: assert property (@(posedge clk) disable iff (rst)
    done_o |-> res_kind_o != 2'b11);
endmodule

bind rxm_match_engine rxm_match_checker #(.IW($clog2(NUM_MB))) u_chk (
  .clk(clk), .rst(rst), .frm_valid_i(frm_valid_i), .busy_o(busy_o),
  .done_o(done_o), .res_kind_o(res_kind_o), .res_idx_o(res_idx_o),
  .res_code_o(res_code_o)
);

// File: tb/rxm_match_engine_tb.sv
module rxm_match_engine_tb;
  localparam int NUM_MB = 16;
  localparam int ID_W   = 29;
  localparam int IW     = 4;
  localparam logic [3:0] C_OFF = 4'b0000, C_EMP = 4'b0100, C_FUL = 4'b0010, C_OVR = 4'b0110;
  localparam logic [1:0] K_NONE = 2'b00, K_ST = 2'b01, K_OV = 2'b10;
  localparam logic [ID_W-1:0] ALL1 = '1;

  logic clk = 1'b0, rst = 1'b1;
  logic freeze_i = 1'b1, indiv_mask_mode_i = 1'b1;
  logic mb_wr_en_i = 1'b0; logic [IW-1:0] mb_wr_idx_i = '0;
  logic [ID_W-1:0] mb_wr_id_i = '0; logic [3:0] mb_wr_code_i = '0;
  logic msk_wr_en_i = 1'b0, msk_wr_shared_i = 1'b0;
  logic [IW-1:0] msk_wr_idx_i = '0; logic [ID_W-1:0] msk_wr_val_i = '0;
  logic frm_valid_i = 1'b0; logic [ID_W-1:0] frm_id_i = '0;
  logic inact_en_i = 1'b0; logic [IW-1:0] inact_idx_i = '0;
  logic busy_o, done_o; logic [1:0] res_kind_o; logic [IW-1:0] res_idx_o; logic [3:0] res_code_o;

  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  rxm_match_engine #(.NUM_MB(NUM_MB), .ID_W(ID_W)) u_dut (.*);

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr_mb(input int idx, input logic [ID_W-1:0] id, input logic [3:0] code);
    mb_wr_en_i = 1'b1; mb_wr_idx_i = IW'(idx); mb_wr_id_i = id; mb_wr_code_i = code;
    @(negedge clk); mb_wr_en_i = 1'b0;
  endtask

  task automatic wr_mask(input logic shared, input int idx, input logic [ID_W-1:0] val);
    msk_wr_en_i = 1'b1; msk_wr_shared_i = shared; msk_wr_idx_i = IW'(idx); msk_wr_val_i = val;
    @(negedge clk); msk_wr_en_i = 1'b0;
  endtask

  task automatic clear_all();
    for (int i = 0; i < NUM_MB; i++) wr_mb(i, '0, C_OFF);
  endtask

  // returns result at the falling edge where done_o is first seen
  task automatic run_frame(input logic [ID_W-1:0] id, input int inact_at, input int inact_mb,
                           input int extra_at, input logic [ID_W-1:0] extra_id,
                           output logic [1:0] k, output int ix, output logic [3:0] c, output int cyc);
    frm_valid_i = 1'b1; frm_id_i = id;
    @(negedge clk); frm_valid_i = 1'b0; cyc = 1;
    while (!done_o && cyc < 60) begin
      inact_en_i = (cyc == inact_at); inact_idx_i = IW'(inact_mb);
      frm_valid_i = (cyc == extra_at); frm_id_i = (cyc == extra_at) ? extra_id : id;
      @(negedge clk); cyc++;
    end
    inact_en_i = 1'b0; frm_valid_i = 1'b0;
    k = res_kind_o; ix = int'(res_idx_o); c = res_code_o;
  endtask

  task automatic expect_frame(input string req, input logic [ID_W-1:0] id,
                              input logic [1:0] ek, input int eix, input logic [3:0] ec);
    logic [1:0] k; int ix; logic [3:0] c; int cyc;
    run_frame(id, -1, 0, -1, '0, k, ix, c, cyc);
    check({req, " kind"}, int'(k), int'(ek));
    check({req, " index"}, ix, eix);
    check({req, " code"}, int'(c), int'(ec));
  endtask

  task automatic t_reset();
    check("R12 busy after reset", int'(busy_o), 0);
    check("R12 done after reset", int'(done_o), 0);
    check("R12 kind after reset", int'(res_kind_o), 0);
    expect_frame("R12/R4 all inactive", 29'h123, K_NONE, 0, C_OFF);
  endtask

  task automatic t_queue();
    logic [1:0] k; int ix; logic [3:0] c; int cyc;
    clear_all();
    wr_mb(2, 29'h123, C_EMP); wr_mb(5, 29'h123, C_EMP);
    run_frame(29'h123, -1, 0, -1, '0, k, ix, c, cyc);
    check("R11 latency", cyc, NUM_MB + 1);
    check("R1 first kind", int'(k), int'(K_ST));
    check("R1 first index", ix, 2);
    check("R1 first code FULL", int'(c), int'(C_FUL));
    expect_frame("R10/R2 second fills mb5", 29'h123, K_ST, 5, C_FUL);
    expect_frame("R10/R3 third overruns mb5", 29'h123, K_OV, 5, C_OVR);
    expect_frame("R3 repeated overrun", 29'h123, K_OV, 5, C_OVR);
  endtask

  task automatic t_skip();
    clear_all();
    wr_mb(1, 29'h55, C_FUL); wr_mb(3, 29'h55, C_OVR); wr_mb(9, 29'h55, C_EMP); wr_mb(12, 29'h55, C_FUL);
    expect_frame("R2 free after occupied", 29'h55, K_ST, 9, C_FUL);
    expect_frame("R3 last matched is mb12", 29'h55, K_OV, 12, C_OVR);
    wr_mb(6, 29'h56, C_EMP);
    expect_frame("R4 id mismatch", 29'h57, K_NONE, 0, C_OFF);
  endtask

  task automatic t_mask();
    indiv_mask_mode_i = 1'b1;
    clear_all();
    wr_mask(1'b0, 4, 29'h1FFF_FFF0);
    wr_mb(4, 29'h100, C_EMP);
    expect_frame("R5 dont-care low bits", 29'h10A, K_ST, 4, C_FUL);
    wr_mb(4, 29'h100, C_EMP);
    expect_frame("R5 compared bit differs", 29'h11A, K_NONE, 0, C_OFF);
    wr_mb(6, 29'h100, C_EMP);
    expect_frame("R6 own mask mb4", 29'h105, K_ST, 4, C_FUL);
    expect_frame("R6 exact mask mb6 rejects", 29'h105, K_OV, 4, C_OVR);
  endtask

  task automatic t_legacy();
    indiv_mask_mode_i = 1'b0;
    clear_all();
    wr_mask(1'b1, 0, 29'h1FFF_FF00);
    wr_mask(1'b1, 1, ALL1);
    wr_mask(1'b1, 2, 29'h1FFF_FFF0);
    wr_mb(3, 29'h200, C_EMP); wr_mb(14, 29'h300, C_EMP); wr_mb(15, 29'h400, C_EMP);
    expect_frame("R7 general mask on mb3", 29'h2AB, K_ST, 3, C_FUL);
    expect_frame("R7 mask A exact on mb14", 29'h305, K_NONE, 0, C_OFF);
    expect_frame("R7 mask B on mb15", 29'h40C, K_ST, 15, C_FUL);
    expect_frame("R7 mask A exact hit", 29'h300, K_ST, 14, C_FUL);
    indiv_mask_mode_i = 1'b1;
  endtask

  task automatic t_freeze();
    clear_all();
    freeze_i = 1'b0;
    wr_mask(1'b0, 4, ALL1);
    wr_mb(4, 29'h100, C_EMP);
    expect_frame("R8 write without freeze ignored", 29'h10A, K_ST, 4, C_FUL);
    freeze_i = 1'b1;
    wr_mask(1'b0, 4, ALL1);
    wr_mb(4, 29'h100, C_EMP);
    expect_frame("R8 write with freeze applied", 29'h10A, K_NONE, 0, C_OFF);
  endtask

  task automatic t_inact();
    logic [1:0] k; int ix; logic [3:0] c; int cyc;
    clear_all();
    wr_mb(2, 29'h77, C_EMP); wr_mb(5, 29'h77, C_EMP);
    // strobe at count 4 is sampled while mailbox 3 is compared
    run_frame(29'h77, 4, 2, -1, '0, k, ix, c, cyc);
    check("R9 winner dropped kind", int'(k), int'(K_ST));
    check("R9 later mailbox wins", ix, 5);
    expect_frame("R9 mb2 stays inactive", 29'h77, K_OV, 5, C_OVR);
    wr_mb(2, 29'h77, C_FUL); wr_mb(5, 29'h77, C_FUL);
    run_frame(29'h77, 7, 5, -1, '0, k, ix, c, cyc);
    check("R9 no candidate after drop", int'(k), int'(K_NONE));
  endtask

  task automatic t_busy();
    logic [1:0] k; int ix; logic [3:0] c; int cyc; int extra_done;
    clear_all();
    wr_mb(7, 29'h9, C_EMP); wr_mb(8, 29'hA, C_EMP);
    run_frame(29'h9, -1, 0, 3, 29'hA, k, ix, c, cyc);
    check("R11 first frame index", ix, 7);
    extra_done = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (done_o) extra_done++;
    end
    check("R11 frame during busy ignored", extra_done, 0);
    expect_frame("R11 mb8 untouched", 29'hA, K_ST, 8, C_FUL);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    for (int i = 0; i < NUM_MB; i++) wr_mask(1'b0, i, ALL1);
    t_queue();
    t_skip();
    t_mask();
    t_legacy();
    t_freeze();
    t_inact();
    t_busy();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule